// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Receiver

This block is the host half of one read slot on a shared, open-drain single-wire debug line. When a start request is accepted, the host pulls the line low for a fixed short time, which marks the beginning of the bit. It then lets the line float so the target can either leave it high or hold it low. The host picks up the line level at a fixed point inside the slot and hands the bit upward with a one-cycle valid strobe. All timing is counted in cycles of a local clock that stands in for the target clock.

The raw line input is asynchronous, so it passes through a synchronizer. The sample count is advanced by the synchronizer depth so that the bit reflects the line as it stood at slot cycle 10. A busy output stays high for the full slot, and start requests are refused while it is high. The logic above this block sequences commands, assembles bytes and discovers the clock rate.

Top module: `dbgwire_bit_rx`

## Requirements
- R1: After reset, drive_low_o, busy_o, rx_valid_o and rx_bit_o are all 0.
- R2: A start_i seen high at a clock edge while busy_o is 0 makes drive_low_o go to 1 in the next cycle, which is slot cycle 0. It stays 1 for exactly 3 cycles (slot cycles 0 to 2) and then returns to 0. A value of 1 means the host pulls the line low, and 0 means the host leaves it at high impedance.
- R3: rx_valid_o is a single-cycle pulse in slot cycle 13. That is sample point 10, plus 2 synchronizer stages, plus 1 output register.
- R4: rx_bit_o equals the line level at slot cycle 10: 1 for a high line and 0 for a low line. A target holding the line low for 13 cycles from its own bit start, with that start lagging the host's first low cycle by 0 or 1 cycle, yields 0. A target that leaves the line alone yields 1.
- R5: busy_o is 1 in slot cycles 0 through 15 and 0 in slot cycle 16.
- R6: A start_i pulse in any slot cycle from 0 to 15 is ignored. It causes no further low drive, no extra rx_valid_o and no change to the slot length.
- R7: With start_i held high continuously, the next slot begins after one idle cycle, so drive_low_o rises again in slot cycle 17.
- R8: rx_bit_o changes only in a cycle where rx_valid_o is 1, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one cycle per target clock cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run one read slot |
| line_i | input | 1 | Level of the shared debug line, asynchronous |
| drive_low_o | output | 1 | 1 = host pulls the line low, 0 = host releases it |
| busy_o | output | 1 | Slot in progress, start requests refused |
| rx_bit_o | output | 1 | Last received bit |
| rx_valid_o | output | 1 | One-cycle strobe, rx_bit_o freshly updated |

## Verification
The bench builds the block with its default parameters: 3 low cycles, sample point 10, 2 synchronizer stages and a 16-cycle slot. With these values, a target zero lasting 13 cycles from a start lagging by 0 or 1 cycle fully covers the sample point. A released line is already high again long before it. The bench varies the bit value, the target's recognition lag and stray requests at every slot cycle. It also holds start_i high so that the one-cycle gap between slots at cycle 16 can be observed.

// File: rtl/dbgwire_pkg.sv
package dbgwire_pkg;

    localparam int unsigned DFLT_LOW_CYCLES  = 3;
    localparam int unsigned DFLT_SAMPLE_AT   = 10;
    localparam int unsigned DFLT_SYNC_STAGES = 2;
    localparam int unsigned DFLT_SLOT_CYCLES = 16;

    // capture register contents
    typedef struct packed {
        logic bit_v;
        logic valid;
    } rx_state_t;

endpackage

// File: rtl/dbgwire_sync.sv
module dbgwire_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        genvar s;
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/dbgwire_slot_timer.sv
module dbgwire_slot_timer #(
    parameter int unsigned SLOT_CYCLES = 16,
    parameter int unsigned CNT_W       = $clog2(SLOT_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    output logic             active_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CYCLES - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (tm_q.active) begin
            if (tm_q.cnt == LAST) begin
                tm_d.active = 1'b0;
                tm_d.cnt    = '0;
            end else begin
                tm_d.cnt = tm_q.cnt + 1'b1;
            end
        end else if (launch_i) begin
            tm_d.active = 1'b1;
            tm_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign active_o = tm_q.active;
    assign cnt_o    = tm_q.cnt;

endmodule

// File: rtl/dbgwire_bit_rx.sv
module dbgwire_bit_rx
    import dbgwire_pkg::*;
#(
    parameter int unsigned LOW_CYCLES  = DFLT_LOW_CYCLES,
    parameter int unsigned SAMPLE_AT   = DFLT_SAMPLE_AT,
    parameter int unsigned SYNC_STAGES = DFLT_SYNC_STAGES,
    parameter int unsigned SLOT_CYCLES = DFLT_SLOT_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic line_i,
    output logic drive_low_o,
    output logic busy_o,
    output logic rx_bit_o,
    output logic rx_valid_o
);

    localparam int unsigned CNT_W = $clog2(SLOT_CYCLES);
    // the synchronizer delays the line, so capture later by its depth
    localparam logic [CNT_W-1:0] CAPTURE_AT = CNT_W'(SAMPLE_AT + SYNC_STAGES);
    localparam logic [CNT_W-1:0] LOW_END    = CNT_W'(LOW_CYCLES);

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic             line_s;
    logic             launch;
    logic             capture;

    rx_state_t rx_d, rx_q;

    assign launch = start_i & ~active;

    dbgwire_slot_timer #(
        .SLOT_CYCLES(SLOT_CYCLES),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch_i(launch),
        .active_o(active),
        .cnt_o   (cnt)
    );

    dbgwire_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(line_i),
        .sync_o (line_s)
    );

    assign capture = active && (cnt == CAPTURE_AT);

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = capture;
        if (capture) begin
            rx_d.bit_v = line_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign drive_low_o = active && (cnt < LOW_END);
    assign busy_o      = active;
    assign rx_bit_o    = rx_q.bit_v;
    assign rx_valid_o  = rx_q.valid;

endmodule

// File: rtl/dbgwire_bit_rx_chk.sv
module dbgwire_bit_rx_chk #(
    parameter int unsigned LOW_CYCLES  = 3,
    parameter int unsigned SAMPLE_AT   = 10,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SLOT_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic drive_low_o,
    input logic busy_o,
    input logic rx_bit_o,
    input logic rx_valid_o
);

    logic [7:0] low_run_q;
    logic [7:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
            age_q     <= '0;
        end else begin
            low_run_q <= drive_low_o ? low_run_q + 8'd1 : 8'd0;
            age_q     <= busy_o ? age_q + 8'd1 : 8'd0;
        end
    end

    // R2
    low_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low_o |-> (low_run_q < 8'(LOW_CYCLES)));

    // R2
    low_len_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_low_o) |-> (low_run_q == 8'(LOW_CYCLES)));

    // R2
    low_inside_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low_o |-> busy_o);

    // R3
    valid_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (age_q == 8'(SAMPLE_AT + SYNC_STAGES + 1)));

    // R3
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R5
    slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ($past(age_q) == 8'(SLOT_CYCLES - 1)));

    // R6
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_low_o) |-> (!$past(busy_o) && $past(start_i)));

    // R8
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> $stable(rx_bit_o));

endmodule

bind dbgwire_bit_rx dbgwire_bit_rx_chk #(
    .LOW_CYCLES (LOW_CYCLES),
    .SAMPLE_AT  (SAMPLE_AT),
    .SYNC_STAGES(SYNC_STAGES),
    .SLOT_CYCLES(SLOT_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .drive_low_o(drive_low_o),
    .busy_o     (busy_o),
    .rx_bit_o   (rx_bit_o),
    .rx_valid_o (rx_valid_o)
);

// File: tb/sim_dbgwire_bit_rx.sv
`timescale 1ns/1ps
module sim_dbgwire_bit_rx;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic tgt_low = 1'b0;
    logic line;
    logic drive_low_o, busy_o, rx_bit_o, rx_valid_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    // open-drain line: either side may pull it low
    assign line = ~(drive_low_o | tgt_low);

    dbgwire_bit_rx u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .line_i     (line),
        .drive_low_o(drive_low_o),
        .busy_o     (busy_o),
        .rx_bit_o   (rx_bit_o),
        .rx_valid_o (rx_valid_o)
    );

    function automatic bit exp_drive(int k, bit hold);
        return (k < 3) || (hold && k >= 17);
    endfunction

    function automatic bit exp_busy(int k, bit hold);
        return (k < 16) || (hold && k >= 17);
    endfunction

    function automatic bit exp_valid(int k);
        return k == 13;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one read slot; stray = slot cycle of a refused request, -1 for none
    task automatic run_slot(bit val, int lag, int stray, bit hold);
        bit drv_ok = 1'b1, busy_ok = 1'b1, val_ok = 1'b1, hold_ok = 1'b1;
        int bad_k = -1;
        int prev_bit = rx_bit_o;
        @(negedge clk);
        start_i = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            start_i = hold || (k == stray);
            tgt_low = (!val && k >= lag && k < lag + 13);
            if (drive_low_o != exp_drive(k, hold)) begin drv_ok = 1'b0; bad_k = k; end
            if (busy_o != exp_busy(k, hold)) begin busy_ok = 1'b0; bad_k = k; end
            if (rx_valid_o != exp_valid(k)) begin val_ok = 1'b0; bad_k = k; end
            if (k < 13 && rx_bit_o != prev_bit) begin hold_ok = 1'b0; bad_k = k; end
            if (k == 13)
                check(rx_bit_o == val, "R4 received bit", rx_bit_o, val);
        end
        check(drv_ok, hold ? "R7 low drive (held start)" : "R2 low drive window", bad_k, -1);
        check(busy_ok, hold ? "R7 busy (held start)" : "R5 busy window", bad_k, -1);
        check(val_ok, "R3 valid strobe timing", bad_k, -1);
        check(hold_ok, "R8 bit held until valid", bad_k, -1);
        check(rx_bit_o == val, "R8 bit held after valid", rx_bit_o, val);
        if (stray >= 0)
            check(drv_ok && busy_ok && val_ok, "R6 refused request", stray, -1);
        start_i = 1'b0;
        tgt_low = 1'b0;
        if (hold) repeat (20) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        check(!drive_low_o && !busy_o && !rx_valid_o && !rx_bit_o,
              "R1 reset outputs", {drive_low_o, busy_o, rx_valid_o, rx_bit_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!drive_low_o && !busy_o && !rx_valid_o && !rx_bit_o,
              "R1 idle after reset", {drive_low_o, busy_o, rx_valid_o, rx_bit_o}, 0);
        // directed corners
        run_slot(1'b1, 0, -1, 1'b0);
        run_slot(1'b0, 0, -1, 1'b0);
        run_slot(1'b0, 1, -1, 1'b0);
        run_slot(1'b1, 1, 15, 1'b0);
        run_slot(1'b0, 1, 0, 1'b0);
        run_slot(1'b1, 0, -1, 1'b1);
        // random mix
        for (int i = 0; i < 40; i++) begin
            int sv = ($urandom % 3 == 0) ? -1 : int'($urandom % 16);
            run_slot(1'($urandom % 2), int'($urandom % 2), sv, 1'b0);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule